// File: doc/BRIEF.md
# Two-Wire Port Expander with Event-Captured Inputs

This block is a two-wire (I2C) slave that gives a host eight output port bits, a small control register and one byte of sampled comparator flags. The analog parts (comparators and a reference DAC) are outside the block. The comparator results arrive as digital input bits. The DAC code and the reference select leave the block as register outputs.

The slave address has seven bits. The upper four bits are fixed at 0111 and the lower three come from strap inputs. A write carries up to two useful data bytes: the port byte first, then the control byte. A read returns one status byte built from the two comparator groups.

The status byte is frozen at one of two moments. In direct mode it is sampled at the acknowledge of the read address. In event mode it is captured on a rising edge of a chosen group-B flag. That captured value is handed to the next read and then cleared and rearmed at that read's address acknowledge.

Top module: `portex_i2c`

## Requirements
- R1: The block responds only to address bits A6..A3 = 0111 followed by A2..A0 equal to `strapAddr` (R/W last, 1 = read). Any other address leaves SDA released and leaves every register output unchanged.
- R2: In a write, the first data byte goes to `portOut`, with data bit 0 on `portOut[0]` and bit 7 on `portOut[7]`.
- R3: In a write, the second data byte sets `latchOnEdge` from bit 7, `refSelDac` from bit 6 and `dacCode` from bits 5..0. Any data byte after the second is acknowledged and has no effect.
- R4: A read returns `{cmpGrpB[2:0], cmpGrpA[4:0]}`, with group B in bits 7..5 and group A in bits 4..0. With `latchOnEdge` = 0 the value is taken at the acknowledge of the read address.
- R5: With `latchOnEdge` = 1, the first rising edge of `cmpGrpB[TRIG_IDX]` (default bit 0) after arming captures the input byte. Later edges are ignored until a read. A read returns the captured byte, or 0 if nothing was captured, and its address acknowledge clears and rearms the capture.
- R6: In event mode, if a trigger rising edge lands in the same clock as the read-address acknowledge, that read returns the previously held byte. The new sample is kept and returned by the following read.
- R7: The block drives SDA low for the ninth clock of each matched address and of each written byte. Read data leaves MSB first. SDA is changed only while SCL is low.
- R8: After a master ACK, further read bytes repeat the same frozen value, even if the inputs have changed. After a master NACK the block releases SDA and ignores clocks until a START.
- R9: A repeated START restarts address reception, and the next write data byte is again treated as the port byte.
- R10: Reset clears `portOut`, `dacCode`, `latchOnEdge` and `refSelDac`, and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low (open drain) |
| strapAddr | input | 3 | Pin-strapped low address bits |
| cmpGrpA | input | 5 | Group A comparator flags |
| cmpGrpB | input | 3 | Group B comparator flags, one of which is the trigger |
| portOut | output | 8 | Output port bits |
| latchOnEdge | output | 1 | 1 selects event capture for the status byte |
| refSelDac | output | 1 | Group B reference select, 1 selects the DAC |
| dacCode | output | 6 | DAC code |

## Verification
The collision that matters is a trigger rising edge in the very clock where the read-address acknowledge loads the transmit byte and rearms the capture. The bench provokes it by raising the trigger flag one clock after the eighth SCL fall of a read address. This lines up the two-flop SCL synchronizer with the single-flop input stage, so both arrive at the same clock. It then judges the outcome over two reads: the first must return the previously held byte, and the second must return the byte sampled at the edge.

// File: rtl/portex_pkg.sv
package portex_pkg;
  localparam int CMP_A_W = 5;
  localparam int CMP_B_W = 3;
  localparam int DAC_W   = 6;
  localparam logic [3:0] ADDR_PREFIX = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK
  } busState_t;

  typedef struct packed {
    logic rdLoad;
    logic wrPort;
    logic wrCtrl;
  } strobe_t;
endpackage

// File: rtl/portex_ctrl.sv
module portex_ctrl
  import portex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic [7:0] txByte,
  output logic       sdaDriveLow,
  output strobe_t    strobe,
  output logic [7:0] rxByte
);
  logic [SYNC_STAGES:0] sclChain, sdaChain;
  assign sclChain[0] = sclIn;
  assign sdaChain[0] = sdaIn;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclChain[g+1] <= 1'b1;
        sdaChain[g+1] <= 1'b1;
      end else begin
        sclChain[g+1] <= sclChain[g];
        sdaChain[g+1] <= sdaChain[g];
      end
    end
  end

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = sclChain[SYNC_STAGES];
  assign sdaS = sdaChain[SYNC_STAGES];

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;

  busState_t state, nState;
  logic [3:0] bitCnt, nCnt;
  logic [7:0] shiftIn, nShift;
  logic [1:0] byteIdx, nIdx;
  logic       isRead, nRead;
  logic       addrMatch;
  logic [2:0] bitSel;

  assign addrMatch = (shiftIn[7:1] == {ADDR_PREFIX, strapAddr});
  assign bitSel    = 3'd7 - bitCnt[2:0];
  assign rxByte    = shiftIn;

  always_comb begin
    nState = state;
    nCnt   = bitCnt;
    nShift = shiftIn;
    nIdx   = byteIdx;
    nRead  = isRead;
    strobe = '0;
    if (startDet) begin
      nState = ST_ADDR;
      nCnt   = '0;
    end else if (stopDet) begin
      nState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            nShift = {shiftIn[6:0], sdaS};
            nCnt   = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (addrMatch) begin
              nState        = ST_ADDR_ACK;
              nRead         = shiftIn[0];
              strobe.rdLoad = shiftIn[0];
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          nCnt   = '0;
          nIdx   = '0;
          nState = isRead ? ST_RD_BYTE : ST_WR_BYTE;
        end
        ST_WR_BYTE: begin
          if (sclRise) begin
            nShift = {shiftIn[6:0], sdaS};
            nCnt   = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nState        = ST_WR_ACK;
            strobe.wrPort = (byteIdx == 2'd0);
            strobe.wrCtrl = (byteIdx == 2'd1);
          end
        end
        ST_WR_ACK: if (sclFall) begin
          nState = ST_WR_BYTE;
          nCnt   = '0;
          if (byteIdx != 2'd2) nIdx = byteIdx + 2'd1;
        end
        ST_RD_BYTE: if (sclFall) begin
          nCnt = bitCnt + 4'd1;
          if (bitCnt == 4'd7) nState = ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (sclRise && sdaS) begin
            nState = ST_IDLE;
          end else if (sclFall) begin
            nState = ST_RD_BYTE;
            nCnt   = '0;
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shiftIn <= '0;
      byteIdx <= '0;
      isRead  <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      state   <= nState;
      bitCnt  <= nCnt;
      shiftIn <= nShift;
      byteIdx <= nIdx;
      isRead  <= nRead;
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                       ((state == ST_RD_BYTE) && !txByte[bitSel]);

  // R7: the data line only moves while the synchronized clock is low
  assert_sda_scl_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !sclS);

  // R1: an address acknowledge only follows a matching address byte
  assert_ack_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ADDR_ACK) |-> ($past(shiftIn[7:1]) == {ADDR_PREFIX, $past(strapAddr)}));
endmodule

// File: rtl/portex_dp.sv
module portex_dp
  import portex_pkg::*;
#(
  parameter int TRIG_IDX = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [7:0]         rxByte,
  input  logic [CMP_A_W-1:0] cmpGrpA,
  input  logic [CMP_B_W-1:0] cmpGrpB,
  output logic [7:0]         txByte,
  output logic [7:0]         portOut,
  output logic               latchOnEdge,
  output logic               refSelDac,
  output logic [DAC_W-1:0]   dacCode
);
  logic [CMP_A_W-1:0] aReg;
  logic [CMP_B_W-1:0] bReg;
  logic               trigPrev, trigRise, armed;
  logic [7:0]         sample, holdVal;

  assign sample   = {bReg, aReg};
  assign trigRise = bReg[TRIG_IDX] & ~trigPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg        <= '0;
      bReg        <= '0;
      trigPrev    <= 1'b0;
      portOut     <= '0;
      latchOnEdge <= 1'b0;
      refSelDac   <= 1'b0;
      dacCode     <= '0;
      txByte      <= '0;
      holdVal     <= '0;
      armed       <= 1'b1;
    end else begin
      aReg     <= cmpGrpA;
      bReg     <= cmpGrpB;
      trigPrev <= bReg[TRIG_IDX];
      if (strobe.wrPort) portOut <= rxByte;
      if (strobe.wrCtrl) begin
        latchOnEdge <= rxByte[7];
        refSelDac   <= rxByte[6];
        dacCode     <= rxByte[DAC_W-1:0];
      end
      if (strobe.rdLoad) txByte <= latchOnEdge ? holdVal : sample;
      if (!latchOnEdge) begin
        holdVal <= '0;
        armed   <= 1'b1;
      end else if (strobe.rdLoad) begin
        holdVal <= trigRise ? sample : '0;
        armed   <= !trigRise;
      end else if (armed && trigRise) begin
        holdVal <= sample;
        armed   <= 1'b0;
      end
    end
  end

  assert_port_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPort |=> (portOut == $past(rxByte)));

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCtrl |=> ({latchOnEdge, refSelDac, dacCode} == $past(rxByte)));

  assert_mode0_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && !latchOnEdge) |=> (txByte == $past(sample)));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (latchOnEdge && !armed && !strobe.rdLoad && !strobe.wrCtrl) |=> $stable(holdVal));

  assert_coincide_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && latchOnEdge && trigRise) |=>
      ((txByte == $past(holdVal)) && (holdVal == $past(sample))));
endmodule

// File: rtl/portex_i2c.sv
module portex_i2c
  import portex_pkg::*;
#(
  parameter int TRIG_IDX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  input  logic [2:0]         strapAddr,
  input  logic [CMP_A_W-1:0] cmpGrpA,
  input  logic [CMP_B_W-1:0] cmpGrpB,
  output logic [7:0]         portOut,
  output logic               latchOnEdge,
  output logic               refSelDac,
  output logic [DAC_W-1:0]   dacCode
);
  strobe_t    strobe;
  logic [7:0] rxByte, txByte;

  portex_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .txByte(txByte), .sdaDriveLow(sdaDriveLow),
    .strobe(strobe), .rxByte(rxByte)
  );

  portex_dp #(.TRIG_IDX(TRIG_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .cmpGrpA(cmpGrpA), .cmpGrpB(cmpGrpB), .txByte(txByte),
    .portOut(portOut), .latchOnEdge(latchOnEdge), .refSelDac(refSelDac),
    .dacCode(dacCode)
  );
endmodule

// File: tb/portex_i2c_tb.sv
module portex_i2c_tb;
  localparam int TRIG = 0;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b0111, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b0111, STRAP, 1'b1};
  // port byte, control byte, group A, group B
  localparam logic [31:0] VEC [4] = '{32'hA5_15_1B_05, 32'h3C_7F_04_02,
                                      32'hFF_00_1F_00, 32'h01_6A_00_07};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [4:0] cmpA = '0;
  logic [2:0] cmpB = '0;
  logic sdaDriveLow, latchOnEdge, refSelDac, sdaLine;
  logic [7:0] portOut;
  logic [5:0] dacCode;
  int errors = 0, checks = 0, sdaViol = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  portex_i2c u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .strapAddr(STRAP), .cmpGrpA(cmpA), .cmpGrpB(cmpB), .portOut(portOut),
    .latchOnEdge(latchOnEdge), .refSelDac(refSelDac), .dacCode(dacCode)
  );

  // R7 monitor: the slave must not move SDA while SCL stays high
  logic prevScl = 1'b1, prevDrive = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaDriveLow != prevDrive)) sdaViol++;
    prevScl   <= sclM;
    prevDrive <= sdaDriveLow;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1; tick(4); sclM = 1; tick(4); sdaM = 0; tick(4); sclM = 0; tick(4);
  endtask

  task automatic busStop();
    sdaM = 0; tick(4); sclM = 1; tick(4); sdaM = 1; tick(4);
  endtask

  task automatic writeByte(input logic [7:0] b, input logic trig, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(4); sclM = 1; tick(8); sclM = 0;
      if (trig && i == 0) begin tick(1); cmpB[TRIG] = 1'b1; tick(1); end
      else tick(2);
    end
    sdaM = 1; tick(4); sclM = 1; tick(4); ack = !sdaLine; tick(4); sclM = 0; tick(2);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    d = '0;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1; tick(4); sclM = 1; tick(4); d[i] = sdaLine; tick(4); sclM = 0; tick(2);
    end
    sdaM = !mAck; tick(4); sclM = 1; tick(8); sclM = 0; tick(2); sdaM = 1;
  endtask

  task automatic writeTwo(input logic [7:0] p, input logic [7:0] c, output logic allAck);
    logic a0, a1, a2;
    busStart(); writeByte(ADDR_W, 0, a0); writeByte(p, 0, a1); writeByte(c, 0, a2); busStop();
    allAck = a0 & a1 & a2;
  endtask

  task automatic readOne(input logic trig, output logic [7:0] d);
    logic a;
    busStart(); writeByte(ADDR_R, trig, a); readByte(0, d); busStop();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] d, d2;
    tick(3);
    check("R10 reset port", portOut, 8'h00);
    check("R10 reset ctrl", {latchOnEdge, refSelDac, dacCode}, 8'h00);
    check("R10 reset sda", sdaDriveLow, 1'b0);
    rstN = 1; tick(4);

    // vector table: direct mode writes and reads (R2, R3, R4, R7)
    for (int v = 0; v < 4; v++) begin
      writeTwo(VEC[v][31:24], VEC[v][23:16], ok);
      check("R7 acks on write", ok, 1'b1);
      check("R2 port byte", portOut, VEC[v][31:24]);
      check("R3 control byte", {latchOnEdge, refSelDac, dacCode}, VEC[v][23:16]);
      cmpA = VEC[v][12:8]; cmpB = VEC[v][2:0]; tick(4);
      readOne(0, d);
      check("R4 read byte", d, {VEC[v][2:0], VEC[v][12:8]});
    end

    // R1: wrong strap bits and wrong prefix are ignored
    busStart(); writeByte({4'b0111, 3'b000, 1'b0}, 0, a); writeByte(8'h99, 0, ok); busStop();
    check("R1 no ack wrong strap", a, 1'b0);
    busStart(); writeByte({4'b0100, STRAP, 1'b0}, 0, a); writeByte(8'h99, 0, ok); busStop();
    check("R1 no ack wrong prefix", a, 1'b0);
    check("R1 port unchanged", portOut, 8'h01);

    // R3: a third data byte is acked and ignored
    busStart(); writeByte(ADDR_W, 0, a); writeByte(8'h10, 0, a); writeByte(8'h05, 0, a);
    writeByte(8'hFF, 0, ok); busStop();
    check("R3 extra byte acked", ok, 1'b1);
    check("R3 extra byte ignored", {portOut, latchOnEdge, refSelDac, dacCode}, 16'h1005);

    // R9: repeated START restarts reception
    busStart(); writeByte(ADDR_W, 0, a); writeByte(8'h11, 0, a);
    busStart(); writeByte(ADDR_W, 0, a); writeByte(8'h22, 0, a); busStop();
    check("R9 port after restart", portOut, 8'h22);
    check("R9 ctrl untouched", {latchOnEdge, refSelDac, dacCode}, 8'h05);

    // R8: acked read repeats the frozen value; NACK then idle
    cmpA = 5'h0C; cmpB = 3'b110; tick(4);
    busStart(); writeByte(ADDR_R, 0, a); readByte(1, d);
    cmpA = 5'h1F; cmpB = 3'b001;
    readByte(0, d2);
    check("R8 first read", d, 8'hCC);
    check("R8 repeated read", d2, 8'hCC);
    begin
      int low = 0;
      for (int i = 0; i < 9; i++) begin
        sdaM = 1; tick(4); sclM = 1; tick(4); if (!sdaLine) low++; tick(4); sclM = 0; tick(2);
      end
      check("R8 released after NACK", low, 0);
    end
    busStop();

    // R5: event capture mode
    cmpB = 3'b000; cmpA = 5'h0A;
    writeTwo(8'h22, 8'h80, ok);
    readOne(0, d);
    check("R5 nothing captured", d, 8'h00);
    cmpA = 5'h11; cmpB = 3'b001; tick(6);
    cmpB = 3'b000; cmpA = 5'h02; tick(6); cmpB = 3'b011; tick(6);
    readOne(0, d);
    check("R5 first edge held", d, 8'h31);
    readOne(0, d);
    check("R5 cleared at read", d, 8'h00);

    // R6: edge in the same clock as the read-address acknowledge
    cmpB = 3'b000; cmpA = 5'h07; tick(6);
    readOne(1, d);
    check("R6 read returns old hold", d, 8'h00);
    readOne(0, d);
    check("R6 edge sample kept", d, 8'h27);

    check("R7 sda stable while scl high", sdaViol, 0);

    // R10: reset after activity
    rstN = 0; tick(2);
    check("R10 reset clears outputs", {portOut, latchOnEdge, refSelDac, dacCode}, 16'h0000);
    rstN = 1; tick(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule